// File: doc/BRIEF.md
# Daisy-Chain Bus Interrupter with Timed Retry

This block raises an interrupt on an asynchronous backplane bus on behalf of one slave device and answers the acknowledge cycle for it. The device presents a level-sensitive request, an interrupt level (1 to 7) and an 8-bit status/ID vector. The block pulls the matching active-low bus interrupt line low. It then follows the acknowledge daisy chain using the incoming acknowledge, the address strobe, the two data strobes and address bits 3:1.

When the acknowledged level is its own, the block drives the vector onto data bits 7:0 and asserts DTACK. When the acknowledged level is not its own, or when the block has no request pending, it passes the acknowledge downstream. The request is sampled as a level. If it is still active after the vector has been taken, the interrupt line is dropped for a fixed number of clock cycles and then raised again, so that a request held by a device that was not serviced is not lost. The block also produces the direction and enable controls for the external address, data and DTACK buffers.

Top module: `irq_daisy_requester`

## Requirements
- R1: While rst_n is low, every interrupt line, iackout_n and dtack_n are high, data_oe is 0 and data_out is 0. This holds from the moment reset is applied, even when a line was being driven.
- R2: From idle, irq_req high with irq_level in 1..7 pulls irq_n[irq_level-1] low one clock later, and leaves the other lines high. A level of 0 or above 7 drives no line.
- R3: The acknowledge sequence is: iackin_n low, then as_n low, then any ds_n bit low, with addr_hi equal to the latched level. It produces data_oe with the latched vector on data_out[7:0] two clocks after the strobe cycle, and dtack_n low one clock after that.
- R4: dtack_n stays low until both ds_n bits are high. The interrupt line is released on the same clock on which dtack_n rises.
- R5: iackin_n low with no pending line, or a level mismatch at the address check, drives iackout_n low. iackout_n and dtack_n are never low together, and iackout_n returns high only after as_n has been seen high.
- R6: Once raised, a line stays low through pass-through cycles and through a drop of irq_req, until this block's own vector is acknowledged.
- R7: If irq_req is still high when dtack_n rises, the line stays released for exactly RETRY_TIMEOUT clocks and is then pulled low again.
- R8: If irq_req falls during the retry wait, the line is not raised again.
- R9: addr_dir is 0 (bus toward device) in every state. data_dir is 1 (device toward bus) during the address check, the vector drive and DTACK, and 0 otherwise. addr_buf_en and dtack_oe are 1 outside reset.
- R10: At most one interrupt line is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Level-sensitive interrupt request from the device |
| irq_level | input | 8 | Requested interrupt level, valid 1..7 |
| irq_vector | input | 8 | Status/ID returned during acknowledge |
| iackin_n | input | 1 | Incoming acknowledge of the daisy chain |
| as_n | input | 1 | Address strobe, already synchronised |
| ds_n | input | 2 | Data strobes, already synchronised |
| addr_hi | input | 3 | Address bits 3:1, the level being acknowledged |
| irq_n | output | 7 | Active-low interrupt lines, bit i is level i+1 |
| iackout_n | output | 1 | Outgoing acknowledge to the next board |
| dtack_n | output | 1 | Data acknowledge |
| data_out | output | 8 | Vector on data bits 7:0 |
| data_oe | output | 1 | Data drive enable |
| addr_dir | output | 1 | Address buffer direction, 1 = device toward bus |
| data_dir | output | 1 | Data buffer direction, 1 = device toward bus |
| addr_buf_en | output | 1 | Address buffer enable |
| dtack_oe | output | 1 | DTACK driver enable |

## Verification
The hardest state to reach from the ports is the retry wait that is interrupted: the block must first finish its own acknowledge while the request is held high, and then the request must fall partway through the countdown. The bench gets there with directed acknowledge sequences on a small timeout. It counts the released clocks edge by edge to confirm the exact reassert point, then repeats the sequence and drops the request after two clocks. A line held through a foreign-level pass-through is reached from the vector table by presenting a mismatching address at the check cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int LVL_W = 3;
    localparam int VEC_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_IRQ,
        ST_WAIT_AS,
        ST_WAIT_DS,
        ST_CHECK,
        ST_DATA_OUT,
        ST_DTACK,
        ST_IACKOUT1,
        ST_IACKOUT2,
        ST_SCHEDULE
    } irq_state_e;

    typedef struct packed {
        irq_state_e         st;
        logic               line;    // interrupt line held low
        logic               resume;  // return to retry wait after pass-through
        logic [LVL_W-1:0]   lvl;
        logic [VEC_W-1:0]   vec;
    } irq_regs_t;

    typedef struct packed {
        logic addr_dir;
        logic data_dir;
        logic addr_en;
        logic dtack_oe;
    } buf_ctl_t;

    function automatic buf_ctl_t buf_for(irq_state_e s);
        buf_ctl_t b;
        b.addr_dir = 1'b0;
        b.addr_en  = 1'b1;
        b.dtack_oe = 1'b1;
        case (s)
            ST_CHECK, ST_DATA_OUT, ST_DTACK: b.data_dir = 1'b1;
            default:                         b.data_dir = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/irq_line_dec.sv
module irq_line_dec #(
    parameter int LVL_W     = 3,
    parameter int NUM_LINES = 7
) (
    input  logic                 en,
    input  logic [LVL_W-1:0]     lvl,
    output logic [NUM_LINES-1:0] line_n
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign line_n[g] = ~(en && (lvl == LVL_W'(g + 1)));
    end

endmodule

// File: rtl/irq_retry_cnt.sv
module irq_retry_cnt #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + CW'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == CW'(TIMEOUT - 1));

endmodule

// File: rtl/irq_daisy_requester.sv
module irq_daisy_requester
    import irq_pkg::*;
#(
    parameter int RETRY_TIMEOUT = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   irq_req,
    input  logic [7:0]             irq_level,
    input  logic [VEC_W-1:0]       irq_vector,
    input  logic                   iackin_n,
    input  logic                   as_n,
    input  logic [1:0]             ds_n,
    input  logic [LVL_W-1:0]       addr_hi,
    output logic [(2**LVL_W)-2:0]  irq_n,
    output logic                   iackout_n,
    output logic                   dtack_n,
    output logic [VEC_W-1:0]       data_out,
    output logic                   data_oe,
    output logic                   addr_dir,
    output logic                   data_dir,
    output logic                   addr_buf_en,
    output logic                   dtack_oe
);

    localparam int NUM_LINES = (2**LVL_W) - 1;
    localparam irq_regs_t REGS_RST = '{st: ST_IDLE, line: 1'b0, resume: 1'b0,
                                       lvl: '0, vec: '0};

    irq_regs_t regs_d, regs_q;
    logic      lvl_ok;
    logic      retry_run;
    logic      retry_done;
    logic      strobe_any;
    logic      strobes_idle;
    buf_ctl_t  buf_q;

    assign lvl_ok       = (irq_level != 8'd0) && (irq_level <= 8'(NUM_LINES));
    assign strobe_any   = (ds_n != 2'b11);
    assign strobes_idle = (ds_n == 2'b11);
    assign retry_run    = (regs_q.st == ST_SCHEDULE);

    irq_retry_cnt #(.TIMEOUT(RETRY_TIMEOUT)) i_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (retry_run),
        .expired (retry_done)
    );

    always_comb begin
        regs_d = regs_q;
        case (regs_q.st)
            ST_IDLE: begin
                if (!iackin_n) begin
                    regs_d.st = ST_IACKOUT1;
                end else if (irq_req && lvl_ok) begin
                    regs_d.st   = ST_IRQ;
                    regs_d.line = 1'b1;
                    regs_d.lvl  = irq_level[LVL_W-1:0];
                    regs_d.vec  = irq_vector;
                end
            end
            ST_IRQ:      if (!iackin_n)  regs_d.st = ST_WAIT_AS;
            ST_WAIT_AS:  if (!as_n)      regs_d.st = ST_WAIT_DS;
            ST_WAIT_DS:  if (strobe_any) regs_d.st = ST_CHECK;
            ST_CHECK: begin
                if (regs_q.line && !iackin_n && (addr_hi == regs_q.lvl))
                    regs_d.st = ST_DATA_OUT;
                else
                    regs_d.st = ST_IACKOUT1;
            end
            ST_DATA_OUT: regs_d.st = ST_DTACK;
            ST_DTACK: begin
                if (strobes_idle) begin
                    regs_d.line = 1'b0;
                    regs_d.st   = irq_req ? ST_SCHEDULE : ST_IDLE;
                end
            end
            ST_IACKOUT1: regs_d.st = ST_IACKOUT2;
            ST_IACKOUT2: begin
                if (as_n) begin
                    regs_d.resume = 1'b0;
                    if (regs_q.line)        regs_d.st = ST_IRQ;
                    else if (regs_q.resume) regs_d.st = ST_SCHEDULE;
                    else                    regs_d.st = ST_IDLE;
                end
            end
            ST_SCHEDULE: begin
                if (!irq_req) begin
                    regs_d.st = ST_IDLE;
                end else if (!iackin_n) begin
                    regs_d.st     = ST_IACKOUT1;
                    regs_d.resume = 1'b1;
                end else if (retry_done) begin
                    regs_d.st   = ST_IRQ;
                    regs_d.line = 1'b1;
                end
            end
            default: regs_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    irq_line_dec #(.LVL_W(LVL_W), .NUM_LINES(NUM_LINES)) i_dec (
        .en     (regs_q.line),
        .lvl    (regs_q.lvl),
        .line_n (irq_n)
    );

    assign iackout_n = !((regs_q.st == ST_IACKOUT1) || (regs_q.st == ST_IACKOUT2));
    assign dtack_n   = (regs_q.st != ST_DTACK);
    assign data_oe   = (regs_q.st == ST_DATA_OUT) || (regs_q.st == ST_DTACK);
    assign data_out  = data_oe ? regs_q.vec : '0;

    assign buf_q       = buf_for(regs_q.st);
    assign addr_dir    = buf_q.addr_dir;
    assign data_dir    = buf_q.data_dir;
    assign addr_buf_en = buf_q.addr_en;
    assign dtack_oe    = buf_q.dtack_oe;

endmodule

// File: rtl/irq_daisy_chk.sv
module irq_daisy_chk #(
    parameter int NUM_LINES = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_n,
    input logic                 iackout_n,
    input logic                 dtack_n,
    input logic                 data_oe,
    input logic                 data_dir,
    input logic                 as_n,
    input logic [1:0]           ds_n
);

    p_single_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~irq_n) <= 1);

    p_dtack_with_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dtack_n |-> data_oe);

    p_dtack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtack_n && (ds_n != 2'b11)) |=> !dtack_n);

    p_no_both_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!iackout_n && !dtack_n));

    p_pass_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iackout_n) |-> $past(as_n));

    p_drive_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> data_dir);

endmodule

bind irq_daisy_requester irq_daisy_chk #(.NUM_LINES(NUM_LINES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_n     (irq_n),
    .iackout_n (iackout_n),
    .dtack_n   (dtack_n),
    .data_oe   (data_oe),
    .data_dir  (data_dir),
    .as_n      (as_n),
    .ds_n      (ds_n)
);

// File: tb/test_irq_daisy_requester.sv
module test_irq_daisy_requester;

    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       irq_req;
    logic [7:0] irq_level;
    logic [7:0] irq_vector;
    logic       iackin_n;
    logic       as_n;
    logic [1:0] ds_n;
    logic [2:0] addr_hi;
    logic [6:0] irq_n;
    logic       iackout_n;
    logic       dtack_n;
    logic [7:0] data_out;
    logic       data_oe;
    logic       addr_dir;
    logic       data_dir;
    logic       addr_buf_en;
    logic       dtack_oe;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_daisy_requester #(.RETRY_TIMEOUT(T)) i_irq_daisy_requester (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_level(irq_level),
        .irq_vector(irq_vector), .iackin_n(iackin_n), .as_n(as_n), .ds_n(ds_n),
        .addr_hi(addr_hi), .irq_n(irq_n), .iackout_n(iackout_n), .dtack_n(dtack_n),
        .data_out(data_out), .data_oe(data_oe), .addr_dir(addr_dir),
        .data_dir(data_dir), .addr_buf_en(addr_buf_en), .dtack_oe(dtack_oe)
    );

    // {req, iackin_n, as_n, ds_n[1:0], addr_hi[2:0] | irq_n[6:0], iackout_n, dtack_n, data_oe, data_dir}
    // Level 3, vector 8'hA5. Covers R2 R3 R4 R5 R6 R9.
    localparam logic [18:0] TBL [26] = '{
        19'b1_1_1_11_000_1111011_1_1_0_0,  // IRQ raised
        19'b1_0_1_11_000_1111011_1_1_0_0,
        19'b1_0_0_11_000_1111011_1_1_0_0,
        19'b1_0_0_10_011_1111011_1_1_0_1,  // check
        19'b1_0_0_10_011_1111011_1_1_1_1,  // vector out
        19'b1_0_0_10_011_1111011_1_0_1_1,  // dtack
        19'b1_0_0_10_011_1111011_1_0_1_1,  // held, strobe low
        19'b0_1_1_11_000_1111111_1_1_0_0,  // released
        19'b1_1_1_11_000_1111011_1_1_0_0,
        19'b1_0_1_11_000_1111011_1_1_0_0,
        19'b1_0_0_11_000_1111011_1_1_0_0,
        19'b1_0_0_00_101_1111011_1_1_0_1,  // check, level 5 mismatch
        19'b1_0_0_00_101_1111011_0_1_0_0,  // pass along
        19'b1_0_0_00_101_1111011_0_1_0_0,
        19'b1_0_0_00_101_1111011_0_1_0_0,  // strobe still low
        19'b1_1_1_11_000_1111011_1_1_0_0,  // back to IRQ, line kept
        19'b0_1_1_11_000_1111011_1_1_0_0,  // request dropped, line kept
        19'b0_0_1_11_000_1111011_1_1_0_0,
        19'b0_0_0_11_000_1111011_1_1_0_0,
        19'b0_0_0_01_011_1111011_1_1_0_1,
        19'b0_0_0_01_011_1111011_1_1_1_1,
        19'b0_0_0_01_011_1111011_1_0_1_1,
        19'b0_1_1_11_000_1111111_1_1_0_0,
        19'b0_0_0_11_000_1111111_0_1_0_0,  // idle pass-through
        19'b0_0_0_11_000_1111111_0_1_0_0,
        19'b0_1_1_11_000_1111111_1_1_0_0
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_idle();
        iackin_n = 1'b1;
        as_n     = 1'b1;
        ds_n     = 2'b11;
        addr_hi  = 3'd0;
    endtask

    // Acknowledge own level; the request level at DTACK exit is keep_req.
    task automatic ack(input logic [2:0] lvl, input logic [7:0] vec, input logic keep_req);
        iackin_n = 1'b0; step();
        as_n = 1'b0;     step();
        ds_n = 2'b00; addr_hi = lvl; step();
        step();
        check(data_oe && data_out == vec, "R3 vector", {23'd0, data_oe, data_out}, {24'd1, vec});
        step();
        check(dtack_n == 1'b0, "R3 dtack", 32'(dtack_n), 32'd0);
        irq_req = keep_req;
        bus_idle();
        step();
        check(dtack_n == 1'b1, "R4 dtack released", 32'(dtack_n), 32'd1);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog (R1..) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        irq_req = 1'b0;
        irq_level = 8'd3;
        irq_vector = 8'hA5;
        bus_idle();
        repeat (2) @(negedge clk);
        // R1 reset state, R9 idle buffer controls
        check(irq_n == 7'h7F && iackout_n && dtack_n && !data_oe && data_out == 8'h00,
              "R1 reset outputs", {22'd0, irq_n, iackout_n, dtack_n, data_oe},
              {22'd0, 7'h7F, 3'b110});
        check(!addr_dir && !data_dir && addr_buf_en && dtack_oe, "R9 idle buffers",
              {28'd0, addr_dir, data_dir, addr_buf_en, dtack_oe}, 32'b0011);
        rst_n = 1'b1;
        step();

        for (int i = 0; i < 26; i++) begin
            logic [18:0] e;
            logic [10:0] got;
            e = TBL[i];
            irq_req  = e[18];
            iackin_n = e[17];
            as_n     = e[16];
            ds_n     = e[15:14];
            addr_hi  = e[13:11];
            step();
            got = {irq_n, iackout_n, dtack_n, data_oe, data_dir};
            checks++;
            if (got != e[10:0] || data_out != (e[1] ? 8'hA5 : 8'h00) || addr_dir) begin
                fails++;
                $display("FAIL table step %0d (R2 R3 R4 R5 R6 R9) actual=%0h/%0h expected=%0h/%0h",
                         i, got, data_out, e[10:0], e[1] ? 8'hA5 : 8'h00);
            end
        end

        // R2: out-of-range levels drive no line
        bus_idle();
        irq_level = 8'd0; irq_req = 1'b1;
        repeat (4) step();
        check(irq_n == 7'h7F, "R2 level 0 ignored", 32'(irq_n), 32'h7F);
        irq_level = 8'd9;
        repeat (4) step();
        check(irq_n == 7'h7F, "R2 level 9 ignored", 32'(irq_n), 32'h7F);

        // R7: retry after held request, level 5
        irq_level = 8'd5; irq_vector = 8'h3C;
        step();
        check(irq_n == 7'h6F, "R2 level 5 line", 32'(irq_n), 32'h6F);
        ack(3'd5, 8'h3C, 1'b1);
        check(irq_n == 7'h7F, "R7 line released", 32'(irq_n), 32'h7F);
        begin
            int n;
            n = 0;
            while (irq_n == 7'h7F && n < 4 * T) begin
                step();
                n++;
            end
            check(n == T && irq_n == 7'h6F, "R7 retry delay", 32'(n), 32'(T));
        end

        // R8: request dropped during the wait
        ack(3'd5, 8'h3C, 1'b1);
        repeat (2) step();
        irq_req = 1'b0;
        repeat (3 * T) step();
        check(irq_n == 7'h7F, "R8 no reassert", 32'(irq_n), 32'h7F);

        // R1: reset while a line is driven
        irq_level = 8'd2; irq_req = 1'b1;
        step();
        check(irq_n == 7'h7D, "R2 level 2 line", 32'(irq_n), 32'h7D);
        rst_n = 1'b0;
        #1;
        check(irq_n == 7'h7F && iackout_n && dtack_n && !data_oe, "R1 reset mid request",
              {25'd0, irq_n}, 32'h7F);
        irq_req = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check(irq_n == 7'h7F, "R1 after reset", 32'(irq_n), 32'h7F);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule